// File: doc/BRIEF.md
# Multi-hart machine timer comparator

This block keeps one 64-bit real-time counter shared by a group of harts. Each hart also has its own 64-bit compare register. The counter advances by one on every cycle in which the timebase tick input is high. Each hart has a level-sensitive timer interrupt output. That output is high whenever the hart's compare value is at or below the current count.

Software reaches the counter and the compare registers through a simple single-cycle register port. Each access carries a valid strobe, a write flag, a size flag (4 or 8 bytes), an address and 64 bits of little-endian write data. Read data comes back one cycle after the request.

The counter sits in an 8-byte slot at a parameterised time base. The compare registers sit in consecutive 8-byte slots starting at a parameterised compare base. Both the counter and the compare registers can be written at any time. A 32-bit access can update either half of a 64-bit register on its own.

Top module: `mtimer_cmp`

## Requirements
- R1: While reset is asserted and right after it is released, the counter reads zero, every compare register reads CMP_INIT (all ones by default), every interrupt output is low and the read response valid is low.
- R2: The counter goes up by exactly one at each clock edge where tick_i is high, and holds its value at edges where tick_i is low and no counter write occurs.
- R3: When a counter write and a tick fall in the same cycle, the counter takes the written value and the increment for that cycle is dropped.
- R4: Inside any 8-byte slot, an 8-byte write at byte offset 0 replaces all 64 bits. A 4-byte write at offset 0 replaces bits 31:0 and keeps bits 63:32. A 4-byte write at offset 4 replaces bits 63:32 with wdata[31:0] and keeps bits 31:0. This holds for the counter slot and for every compare slot.
- R5: An 8-byte write aimed at byte offset 4 of any slot changes no register.
- R6: The compare register of hart h sits in the slot at address CMP_BASE + 8*h, for h = 0 to NUM_HARTS-1.
- R7: timer_irq_o[h] is high exactly when compare[h] <= counter (unsigned 64-bit). With IRQ_REG=0 the new level is visible in the same cycle after the edge that wrote the compare register or moved the counter; it rises when a past value is written and falls when a future value is written.
- R8: Any write to the counter re-evaluates every hart's interrupt against its compare value. An interrupt output falls only after a write to the counter or to that hart's compare register.
- R9: rsp_valid_o is high for exactly the one cycle after each read request. In that cycle rsp_rdata_o holds the register as it was in the request cycle:
  - all 64 bits for an 8-byte read at offset 0;
  - bits 31:0 in rsp_rdata_o[31:0] with the upper half zero for a 4-byte read at offset 0;
  - bits 63:32 in rsp_rdata_o[31:0] with the upper half zero for a read of either size at offset 4.
- R10: An access with address bits 1:0 non-zero, or an address outside the counter slot and the compare window, is undecoded. An undecoded read returns zero and an undecoded write changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick, one-cycle pulse per count |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size8_i | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| req_addr_i | input | ADDR_W | Byte address of the access |
| req_wdata_i | input | 64 | Write data, little-endian |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata_o | output | 64 | Read data |
| timer_irq_o | output | NUM_HARTS | Per-hart timer interrupt level |

## Verification
The bench builds the block with three harts, a compare base of 0x100 and a time base of 0x40, and uses the combinational interrupt variant. Because the hart count is not a power of two, the bench can address the hole right after the last compare slot, and it checks that this hole is undecoded. With both bases non-zero and far apart, a wrong base subtraction or a wrong slot index lands on a wrong or empty address. That shows up as a zero or stale read. The same-cycle interrupt path lets every compare and counter write be checked on the interrupt pins one cycle later, including the equal-value boundary.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

   localparam int unsigned WORD_W = 64;
   localparam int unsigned HALF_W = 32;

   typedef logic [WORD_W-1:0] word_t;

   // Merge write data into a 64-bit register according to access shape.
   function automatic word_t merge_word(word_t old_v, word_t new_v, logic full, logic upper);
      if (full) begin
         return new_v;
      end
      if (upper) begin
         return {new_v[HALF_W-1:0], old_v[HALF_W-1:0]};
      end
      return {old_v[WORD_W-1:HALF_W], new_v[HALF_W-1:0]};
   endfunction

   // Select the read lane: upper half at offset 4, full or lower at offset 0.
   function automatic word_t read_lane(word_t v, logic full, logic upper);
      if (upper) begin
         return {{HALF_W{1'b0}}, v[WORD_W-1:HALF_W]};
      end
      if (full) begin
         return v;
      end
      return {{HALF_W{1'b0}}, v[HALF_W-1:0]};
   endfunction

endpackage

// File: rtl/mtc_decode.sv
module mtc_decode #(
   parameter int unsigned       ADDR_W    = 16,
   parameter int unsigned       NUM_HARTS = 4,
   parameter int unsigned       HART_W    = 2,
   parameter logic [ADDR_W-1:0] CMP_BASE  = '0,
   parameter logic [ADDR_W-1:0] TIME_BASE = '1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              size8,
   output logic              hit_time,
   output logic              hit_cmp,
   output logic [HART_W-1:0] hart_idx,
   output logic              upper,
   output logic              wr_ok
);

   localparam int unsigned     SPAN   = NUM_HARTS * 8;
   localparam logic [ADDR_W:0] SPAN_W = (ADDR_W + 1)'(SPAN);

   logic [ADDR_W:0] rel;
   logic            aligned;

   // Borrow out of the subtraction puts addresses below the base out of range.
   assign rel      = {1'b0, addr} - {1'b0, CMP_BASE};
   assign aligned  = (addr[1:0] == 2'b00);
   assign upper    = addr[2];
   assign hit_cmp  = aligned && (rel < SPAN_W);
   assign hit_time = aligned && (addr[ADDR_W-1:3] == TIME_BASE[ADDR_W-1:3]);
   assign hart_idx = rel[HART_W+2:3];
   assign wr_ok    = !(size8 && addr[2]);

endmodule

// File: rtl/mtc_time_counter.sv
module mtc_time_counter
   import mtc_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  tick,
   input  logic  wr_en,
   input  logic  wr_full,
   input  logic  wr_upper,
   input  word_t wr_data,
   output word_t count
);

   word_t cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (wr_en) begin
         cnt_q <= merge_word(cnt_q, wr_data, wr_full, wr_upper);
      end else if (tick) begin
         cnt_q <= cnt_q + word_t'(1);
      end
   end

   assign count = cnt_q;

endmodule

// File: rtl/mtc_cmp_bank.sv
module mtc_cmp_bank
   import mtc_pkg::*;
#(
   parameter int unsigned NUM_HARTS = 4,
   parameter int unsigned HART_W    = 2,
   parameter word_t       CMP_INIT  = '1,
   parameter bit          IRQ_REG   = 1'b0
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [HART_W-1:0]                wr_hart,
   input  logic                             wr_full,
   input  logic                             wr_upper,
   input  word_t                            wr_data,
   input  word_t                            now,
   output logic [NUM_HARTS-1:0][WORD_W-1:0] cmp,
   output logic [NUM_HARTS-1:0]             irq
);

   localparam bit IRQ_RST = (CMP_INIT == '0);

   for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
      word_t cmp_q;
      logic  due;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cmp_q <= CMP_INIT;
         end else if (wr_en && (wr_hart == HART_W'(h))) begin
            cmp_q <= merge_word(cmp_q, wr_data, wr_full, wr_upper);
         end
      end

      assign due    = (cmp_q <= now);
      assign cmp[h] = cmp_q;

      if (IRQ_REG) begin : g_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_q <= IRQ_RST;
            end else begin
               irq_q <= due;
            end
         end
         assign irq[h] = irq_q;
      end else begin : g_comb
         assign irq[h] = due;
      end
   end

endmodule

// File: rtl/mtimer_cmp.sv
module mtimer_cmp
   import mtc_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 16,
   parameter int unsigned       NUM_HARTS = 4,
   parameter logic [ADDR_W-1:0] CMP_BASE  = 16'h0000,
   parameter logic [ADDR_W-1:0] TIME_BASE = 16'h7FF8,
   parameter logic [63:0]       CMP_INIT  = '1,
   parameter bit                IRQ_REG   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   input  logic                 req_valid_i,
   input  logic                 req_write_i,
   input  logic                 req_size8_i,
   input  logic [ADDR_W-1:0]    req_addr_i,
   input  logic [63:0]          req_wdata_i,
   output logic                 rsp_valid_o,
   output logic [63:0]          rsp_rdata_o,
   output logic [NUM_HARTS-1:0] timer_irq_o
);

   localparam int unsigned HART_W   = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
   localparam longint      SPAN     = longint'(NUM_HARTS) * 8;
   localparam longint      CMP_LO   = longint'(CMP_BASE);
   localparam longint      TIME_LO  = longint'(TIME_BASE);
   localparam longint      ADDR_TOP = longint'(1) << ADDR_W;

   // Elaboration-time parameter checks
   if (ADDR_W < 8 || ADDR_W > 31) begin : g_bad_addr_w
      $error("mtimer_cmp: ADDR_W must be within 8..31");
   end
   if (NUM_HARTS < 1) begin : g_bad_harts
      $error("mtimer_cmp: NUM_HARTS must be at least 1");
   end
   if (CMP_BASE[2:0] != 3'b000 || TIME_BASE[2:0] != 3'b000) begin : g_bad_align
      $error("mtimer_cmp: bases must be 8-byte aligned");
   end
   if (CMP_LO + SPAN > ADDR_TOP) begin : g_bad_span
      $error("mtimer_cmp: compare window exceeds address space");
   end
   if (TIME_LO >= CMP_LO && TIME_LO < CMP_LO + SPAN) begin : g_bad_overlap
      $error("mtimer_cmp: time slot overlaps compare window");
   end

   logic                             hit_time;
   logic                             hit_cmp;
   logic [HART_W-1:0]                hart_idx;
   logic                             upper;
   logic                             wr_ok;
   logic                             wr_fire;
   word_t                            time_q;
   logic [NUM_HARTS-1:0][WORD_W-1:0] cmp_q;
   word_t                            cmp_sel;
   word_t                            rd_mux;
   logic                             rsp_valid_q;
   word_t                            rsp_rdata_q;

   mtc_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_HARTS (NUM_HARTS),
      .HART_W    (HART_W),
      .CMP_BASE  (CMP_BASE),
      .TIME_BASE (TIME_BASE)
   ) u_decode (
      .addr     (req_addr_i),
      .size8    (req_size8_i),
      .hit_time (hit_time),
      .hit_cmp  (hit_cmp),
      .hart_idx (hart_idx),
      .upper    (upper),
      .wr_ok    (wr_ok)
   );

   assign wr_fire = req_valid_i && req_write_i && wr_ok;

   mtc_time_counter u_time (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_i),
      .wr_en    (wr_fire && hit_time),
      .wr_full  (req_size8_i),
      .wr_upper (upper),
      .wr_data  (req_wdata_i),
      .count    (time_q)
   );

   mtc_cmp_bank #(
      .NUM_HARTS (NUM_HARTS),
      .HART_W    (HART_W),
      .CMP_INIT  (CMP_INIT),
      .IRQ_REG   (IRQ_REG)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_fire && hit_cmp),
      .wr_hart  (hart_idx),
      .wr_full  (req_size8_i),
      .wr_upper (upper),
      .wr_data  (req_wdata_i),
      .now      (time_q),
      .cmp      (cmp_q),
      .irq      (timer_irq_o)
   );

   always_comb begin
      cmp_sel = '0;
      for (int h = 0; h < NUM_HARTS; h++) begin
         if (hart_idx == HART_W'(h)) begin
            cmp_sel = cmp_q[h];
         end
      end
   end

   always_comb begin
      rd_mux = '0;
      if (hit_time) begin
         rd_mux = read_lane(time_q, req_size8_i, upper);
      end else if (hit_cmp) begin
         rd_mux = read_lane(cmp_sel, req_size8_i, upper);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_rdata_q <= '0;
      end else begin
         rsp_valid_q <= req_valid_i && !req_write_i;
         rsp_rdata_q <= (req_valid_i && !req_write_i) ? rd_mux : '0;
      end
   end

   assign rsp_valid_o = rsp_valid_q;
   assign rsp_rdata_o = rsp_rdata_q;

endmodule

// File: rtl/mtc_checker.sv
module mtc_checker #(
   parameter int unsigned NUM_HARTS = 4,
   parameter int unsigned HART_W    = 2,
   parameter bit          IRQ_REG   = 1'b0
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        tick_i,
   input logic                        req_valid_i,
   input logic                        req_write_i,
   input logic                        req_size8_i,
   input logic                        req_upper_i,
   input logic [63:0]                 req_wdata_i,
   input logic                        rsp_valid_o,
   input logic [63:0]                 rsp_rdata_o,
   input logic [NUM_HARTS-1:0]        timer_irq_o,
   input logic [63:0]                 time_q,
   input logic [NUM_HARTS-1:0][63:0]  cmp_q,
   input logic                        hit_time,
   input logic                        hit_cmp,
   input logic [HART_W-1:0]           hart_idx,
   input logic                        wr_ok
);

   logic                 wr_any;
   logic                 time_wr;
   logic                 rd_req;
   logic [NUM_HARTS-1:0] wr_hit;

   assign wr_any  = req_valid_i && req_write_i && wr_ok;
   assign time_wr = wr_any && hit_time;
   assign rd_req  = req_valid_i && !req_write_i;

   always_comb begin
      for (int h = 0; h < NUM_HARTS; h++) begin
         wr_hit[h] = time_wr || (wr_any && hit_cmp && (hart_idx == HART_W'(h)));
      end
   end

   AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !time_wr) |=> (time_q == $past(time_q) + 64'd1));  // R2

   AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !time_wr) |=> $stable(time_q));  // R2

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (time_wr && tick_i && req_size8_i) |=> (time_q == $past(req_wdata_i)));  // R3

   AST_WIDE_HI_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_write_i && req_size8_i && req_upper_i && !tick_i)
         |=> ($stable(time_q) && $stable(cmp_q)));  // R5

   AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rsp_valid_o);  // R9

   AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rsp_valid_o);  // R9

   AST_UNDECODED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !hit_time && !hit_cmp) |=> (rsp_rdata_o == 64'd0));  // R10

   for (genvar h = 0; h < NUM_HARTS; h++) begin : g_fall
      if (IRQ_REG) begin : g_late
         AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(timer_irq_o[h]) |-> $past(wr_hit[h], 2));  // R8
      end else begin : g_now
         AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(timer_irq_o[h]) |-> $past(wr_hit[h]));  // R8
      end
   end

endmodule

bind mtimer_cmp mtc_checker #(
   .NUM_HARTS (NUM_HARTS),
   .HART_W    (HART_W),
   .IRQ_REG   (IRQ_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_i      (tick_i),
   .req_valid_i (req_valid_i),
   .req_write_i (req_write_i),
   .req_size8_i (req_size8_i),
   .req_upper_i (req_addr_i[2]),
   .req_wdata_i (req_wdata_i),
   .rsp_valid_o (rsp_valid_o),
   .rsp_rdata_o (rsp_rdata_o),
   .timer_irq_o (timer_irq_o),
   .time_q      (time_q),
   .cmp_q       (cmp_q),
   .hit_time    (hit_time),
   .hit_cmp     (hit_cmp),
   .hart_idx    (hart_idx),
   .wr_ok       (wr_ok)
);

// File: tb/tb_mtimer_cmp.sv
module tb_mtimer_cmp;

   localparam int          CLK_PERIOD = 10;
   localparam int          NH         = 3;
   localparam logic [15:0] CB         = 16'h0100;
   localparam logic [15:0] TB         = 16'h0040;
   localparam logic [63:0] ONES       = 64'hFFFF_FFFF_FFFF_FFFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_i = 1'b0;
   logic          req_valid_i = 1'b0;
   logic          req_write_i = 1'b0;
   logic          req_size8_i = 1'b0;
   logic [15:0]   req_addr_i = '0;
   logic [63:0]   req_wdata_i = '0;
   logic          rsp_valid_o;
   logic [63:0]   rsp_rdata_o;
   logic [NH-1:0] timer_irq_o;

   int checks = 0;
   int errors = 0;

   mtimer_cmp #(
      .ADDR_W    (16),
      .NUM_HARTS (NH),
      .CMP_BASE  (CB),
      .TIME_BASE (TB),
      .CMP_INIT  (ONES),
      .IRQ_REG   (1'b0)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick_i),
      .req_valid_i (req_valid_i),
      .req_write_i (req_write_i),
      .req_size8_i (req_size8_i),
      .req_addr_i  (req_addr_i),
      .req_wdata_i (req_wdata_i),
      .rsp_valid_o (rsp_valid_o),
      .rsp_rdata_o (rsp_rdata_o),
      .timer_irq_o (timer_irq_o)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic bwrite(logic [15:0] a, logic s8, logic [63:0] d);
      @(negedge clk);
      req_valid_i = 1'b1; req_write_i = 1'b1; req_size8_i = s8;
      req_addr_i = a; req_wdata_i = d;
      @(negedge clk);
      req_valid_i = 1'b0; req_write_i = 1'b0;
   endtask

   task automatic bread(logic [15:0] a, logic s8, output logic [63:0] d, output logic v);
      @(negedge clk);
      req_valid_i = 1'b1; req_write_i = 1'b0; req_size8_i = s8; req_addr_i = a;
      @(negedge clk);
      req_valid_i = 1'b0;
      d = rsp_rdata_o;
      v = rsp_valid_o;
   endtask

   task automatic expect_read(string req, string what, logic [15:0] a, logic s8, logic [63:0] exp);
      logic [63:0] d;
      logic        v;
      bread(a, s8, d, v);
      check(req, {what, " valid"}, {63'd0, v}, 64'd1);
      check(req, what, d, exp);
   endtask

   task automatic expect_irq(string req, string what, logic [NH-1:0] exp);
      check(req, what, 64'(timer_irq_o), 64'(exp));
   endtask

   task automatic t_reset();
      check("R1", "rsp_valid after reset", {63'd0, rsp_valid_o}, 64'd0);
      expect_irq("R1", "irq after reset", 3'b000);
      expect_read("R1", "time after reset", TB, 1'b1, 64'd0);
      for (int h = 0; h < NH; h++) begin
         expect_read("R1", "cmp after reset", CB + 16'(8 * h), 1'b1, ONES);
      end
      @(negedge clk);
      check("R9", "rsp_valid drops when idle", {63'd0, rsp_valid_o}, 64'd0);
   endtask

   task automatic t_tick();
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         tick_i = 1'b1;
      end
      @(negedge clk);
      tick_i = 1'b0;
      expect_read("R2", "time after 5 ticks", TB, 1'b1, 64'd5);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         tick_i = (i != 1) && (i != 4);
      end
      @(negedge clk);
      tick_i = 1'b0;
      expect_read("R2", "time after gapped ticks", TB, 1'b1, 64'd9);
      repeat (4) @(negedge clk);
      expect_read("R2", "time holds without tick", TB, 1'b1, 64'd9);
   endtask

   task automatic t_tick_vs_write();
      @(negedge clk);
      tick_i = 1'b1;
      req_valid_i = 1'b1; req_write_i = 1'b1; req_size8_i = 1'b1;
      req_addr_i = TB; req_wdata_i = 64'h100;
      @(negedge clk);
      tick_i = 1'b0; req_valid_i = 1'b0; req_write_i = 1'b0;
      expect_read("R3", "write beats tick", TB, 1'b1, 64'h100);
      @(negedge clk);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      expect_read("R3", "counting resumes", TB, 1'b1, 64'h101);
   endtask

   task automatic t_split_time();
      bwrite(TB, 1'b1, 64'h1111_2222_3333_4444);
      bwrite(TB, 1'b0, 64'hFFFF_FFFF_AAAA_BBBB);
      expect_read("R4", "time low-half write", TB, 1'b1, 64'h1111_2222_AAAA_BBBB);
      bwrite(TB + 16'd4, 1'b0, 64'h0000_0000_CCCC_DDDD);
      expect_read("R4", "time high-half write", TB, 1'b1, 64'hCCCC_DDDD_AAAA_BBBB);
      expect_read("R9", "4-byte read high", TB + 16'd4, 1'b0, 64'h0000_0000_CCCC_DDDD);
      expect_read("R9", "8-byte read at +4", TB + 16'd4, 1'b1, 64'h0000_0000_CCCC_DDDD);
      expect_read("R9", "4-byte read low", TB, 1'b0, 64'h0000_0000_AAAA_BBBB);
   endtask

   task automatic t_reject();
      bwrite(TB + 16'd4, 1'b1, 64'd0);
      expect_read("R5", "time after wide write at +4", TB, 1'b1, 64'hCCCC_DDDD_AAAA_BBBB);
      bwrite(CB + 16'd8, 1'b1, 64'h0123_4567_89AB_CDEF);
      bwrite(CB + 16'd12, 1'b1, 64'd0);
      expect_read("R5", "cmp1 after wide write at +4", CB + 16'd8, 1'b1, 64'h0123_4567_89AB_CDEF);
      expect_read("R9", "cmp1 4-byte low", CB + 16'd8, 1'b0, 64'h0000_0000_89AB_CDEF);
      expect_read("R9", "cmp1 4-byte high", CB + 16'd12, 1'b0, 64'h0000_0000_0123_4567);
   endtask

   task automatic t_cmp_irq();
      bwrite(TB, 1'b1, 64'd1000);
      expect_irq("R7", "all future", 3'b000);
      bwrite(CB, 1'b1, 64'd999);
      expect_irq("R7", "cmp0 in past", 3'b001);
      bwrite(CB + 16'd8, 1'b1, 64'd1000);
      expect_irq("R7", "cmp1 equal to time", 3'b011);
      bwrite(CB + 16'd16, 1'b1, 64'd1001);
      expect_irq("R7", "cmp2 one ahead", 3'b011);
      @(negedge clk);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      expect_irq("R7", "tick reaches cmp2", 3'b111);
      bwrite(CB, 1'b1, 64'd5000);
      expect_irq("R7", "future cmp0 drops irq", 3'b110);
      expect_read("R6", "cmp0 slot", CB, 1'b1, 64'd5000);
      expect_read("R6", "cmp1 slot", CB + 16'd8, 1'b1, 64'd1000);
      expect_read("R6", "cmp2 slot", CB + 16'd16, 1'b1, 64'd1001);
   endtask

   task automatic t_time_reeval();
      bwrite(TB, 1'b1, 64'd0);
      expect_irq("R8", "time to zero drops all", 3'b000);
      bwrite(TB, 1'b0, 64'd1000);
      expect_irq("R8", "time low write to 1000", 3'b010);
      bwrite(TB, 1'b1, 64'd6000);
      expect_irq("R8", "time jump raises all", 3'b111);
      bwrite(CB + 16'd16, 1'b1, 64'h1_0000_0000);
      expect_irq("R4", "cmp2 far future", 3'b011);
      bwrite(CB + 16'd20, 1'b0, 64'd0);
      expect_irq("R4", "cmp2 high cleared", 3'b111);
      bwrite(CB + 16'd16, 1'b0, 64'd7000);
      expect_irq("R4", "cmp2 low to 7000", 3'b011);
      expect_read("R4", "cmp2 merged", CB + 16'd16, 1'b1, 64'd7000);
   endtask

   task automatic t_undecoded();
      expect_read("R10", "past last slot", CB + 16'd24, 1'b1, 64'd0);
      expect_read("R10", "misaligned time", TB + 16'd1, 1'b0, 64'd0);
      expect_read("R10", "empty slot after time", TB + 16'd8, 1'b1, 64'd0);
      bwrite(TB + 16'd2, 1'b1, 64'd0);
      expect_read("R10", "misaligned write ignored", TB, 1'b1, 64'd6000);
      bwrite(CB + 16'd24, 1'b1, 64'd0);
      expect_irq("R10", "write past last slot ignored", 3'b011);
      expect_read("R10", "cmp2 untouched", CB + 16'd16, 1'b1, 64'd7000);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_tick();
      t_tick_vs_write();
      t_split_time();
      t_reject();
      t_cmp_irq();
      t_time_reeval();
      t_undecoded();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule